// File: doc/BRIEF.md
# Serial EEPROM-Style I2C Read Target

This block is an I2C target that serves read traffic for a 16384-byte memory. The memory sits next to it on a plain asynchronous read port. SCL and SDA are oversampled by the system clock. The block detects START, repeated START and STOP on the bus. It responds to a 7-bit device address made of a fixed `1010` prefix and three strap bits. SDA is driven only as an open-drain pull-down enable.

A master sets the read location with a write-direction phase that carries a two-byte word address. The master then issues a repeated START and reads in the read direction. It can also skip the address phase and read from wherever the internal counter was left. The 14-bit counter survives between transactions. It steps once for every byte shifted out and rolls over from the last location to the first. Bytes keep streaming for as long as the master acknowledges.

Top module: `i2c_mem_reader`

## Requirements
- R1: The target answers only the address byte whose upper seven bits are `1010` followed by `devSel[2:0]`, and bit 0 is the direction (1 = read). On any other address it leaves SDA released for the acknowledge slot and for all later clocks, until the next START or STOP.
- R2: In a write-direction transfer the two bytes after the address byte form the word address, high byte first. Each of the three bytes is acknowledged by pulling SDA low through the whole ninth SCL high phase. The counter (visible on `memAddr`) holds the new address once the low byte has been taken.
- R3: Bits 7 and 6 of the high word-address byte are ignored: high byte 0xC1 with low byte 0x23 selects location 0x0123.
- R4: After acknowledging a read-direction address byte, the target shifts out the byte at `memAddr`, MSB first. A 0 bit is driven low and a 1 bit is released.
- R5: When the master acknowledges a data byte (SDA low in the ninth pulse), the next byte comes from the following address.
- R6: After location 16383 the counter returns to 0 and output continues within the same transfer.
- R7: Every byte shifted out advances the counter by one, whether or not the master acknowledges it. After a non-acknowledge the target releases SDA.
- R8: A read-direction transfer with no preceding address phase starts at the counter value left by the previous transfer.
- R9: A START that arrives in the middle of a byte abandons that byte without touching the counter, and address reception begins again.
- R10: Outside START and STOP handling, the target changes SDA only while the synchronised SCL is low.
- R11: A STOP returns the target to idle with SDA released and the counter unchanged.
- R12: After reset SDA is released and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| devSel | input | 3 | Strap bits forming the low part of the device address |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| memAddr | output | 14 | Current read location (the address counter) |
| memData | input | 8 | Byte stored at `memAddr`, read combinationally |

## Verification
The assertions check four things on every clock. SDA may only move while the synchronised SCL is low, apart from START and STOP handling. A START or STOP always leaves SDA released. The counter moves only when a load or step strobe asks for it, and a step always adds exactly one modulo the array size. Whether the right byte comes out in the right bit order cannot be seen by a property, so the bench's transfers have to show it. The same holds for address matching, the ignored upper address bits, the rollover at the end of the array, and the abort on a mid-byte START. The bench drives these as complete bus transfers against its own counter and memory model. It compares SDA on every clock of each SCL high phase.

// File: rtl/i2crd_pkg.sv
package i2crd_pkg;

  localparam logic [3:0] TYPE_ID = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_AHI,
    S_ALO,
    S_ACKDEV,
    S_ACKHI,
    S_ACKLO,
    S_TX,
    S_MACK
  } rdState_e;

  typedef struct packed {
    logic shiftIn;
    logic loadHi;
    logic loadCnt;
    logic loadTx;
    logic shiftTx;
    logic incAddr;
  } dpCtl_t;

endpackage

// File: rtl/i2crd_datapath.sv
module i2crd_datapath
  import i2crd_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  input  logic [7:0]        memData,
  output logic              sclSync,
  output logic              sdaSync,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startEv,
  output logic              stopEv,
  output logic [7:0]        rxByte,
  output logic              txBit,
  output logic [ADDR_W-1:0] memAddr
);

  localparam int HI_W = ADDR_W - 8;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic                   sclPrev, sdaPrev;
  logic [HI_W-1:0]        hiReg;
  logic [7:0]             txReg;
  logic [ADDR_W-1:0]      addrCnt;

  // Two-line metastability filter, depth set by SYNC_STAGES
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe[0] <= sclIn;
      sdaPipe[0] <= sdaIn;
      for (int k = 1; k < SYNC_STAGES; k++) begin
        sclPipe[k] <= sclPipe[k-1];
        sdaPipe[k] <= sdaPipe[k-1];
      end
      sclPrev <= sclPipe[SYNC_STAGES-1];
      sdaPrev <= sdaPipe[SYNC_STAGES-1];
    end
  end

  assign sclSync = sclPipe[SYNC_STAGES-1];
  assign sdaSync = sdaPipe[SYNC_STAGES-1];
  assign sclRise = sclSync & ~sclPrev;
  assign sclFall = ~sclSync & sclPrev;
  assign startEv = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopEv  = sclSync & sclPrev & ~sdaPrev & sdaSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      hiReg   <= '0;
      txReg   <= '0;
      addrCnt <= '0;
    end else begin
      if (ctl.shiftIn) rxByte <= {rxByte[6:0], sdaSync};
      if (ctl.loadHi)  hiReg  <= rxByte[HI_W-1:0];
      if (ctl.loadCnt)      addrCnt <= {hiReg, rxByte};
      else if (ctl.incAddr) addrCnt <= addrCnt + 1'b1;
      if (ctl.loadTx)       txReg <= memData;
      else if (ctl.shiftTx) txReg <= {txReg[6:0], 1'b0};
    end
  end

  assign txBit   = txReg[7];
  assign memAddr = addrCnt;

endmodule

// File: rtl/i2crd_ctrl.sv
module i2crd_ctrl
  import i2crd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaSync,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  input  logic [2:0] devSel,
  output dpCtl_t     ctl,
  output logic       sdaOe
);

  rdState_e   st, stNx;
  logic [3:0] bitCnt, bitNx;
  logic       rwBit, rwNx;
  logic       mAck, mAckNx;

  always_comb begin
    stNx   = st;
    bitNx  = bitCnt;
    rwNx   = rwBit;
    mAckNx = mAck;
    ctl    = '0;
    if (startEv) begin
      stNx  = S_DEV;
      bitNx = '0;
    end else if (stopEv) begin
      stNx = S_IDLE;
    end else begin
      case (st)
        S_DEV, S_AHI, S_ALO: begin
          if (sclRise && bitCnt != 4'd8) begin
            ctl.shiftIn = 1'b1;
            bitNx       = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            bitNx = '0;
            case (st)
              S_DEV: begin
                if (rxByte[7:1] == {TYPE_ID, devSel}) begin
                  stNx = S_ACKDEV;
                  rwNx = rxByte[0];
                end else begin
                  stNx = S_IDLE;
                end
              end
              S_AHI: begin
                ctl.loadHi = 1'b1;
                stNx       = S_ACKHI;
              end
              default: begin
                ctl.loadCnt = 1'b1;
                stNx        = S_ACKLO;
              end
            endcase
          end
        end
        S_ACKDEV: if (sclFall) begin
          if (rwBit) begin
            ctl.loadTx = 1'b1;
            stNx       = S_TX;
          end else begin
            stNx = S_AHI;
          end
        end
        S_ACKHI: if (sclFall) stNx = S_ALO;
        S_ACKLO: if (sclFall) stNx = S_IDLE;
        S_TX: if (sclFall) begin
          ctl.shiftTx = 1'b1;
          if (bitCnt == 4'd7) begin
            bitNx       = '0;
            ctl.incAddr = 1'b1;
            stNx        = S_MACK;
          end else begin
            bitNx = bitCnt + 4'd1;
          end
        end
        S_MACK: begin
          if (sclRise) mAckNx = ~sdaSync;
          if (sclFall) begin
            if (mAck) begin
              ctl.loadTx = 1'b1;
              stNx       = S_TX;
            end else begin
              stNx = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= S_IDLE;
      bitCnt <= '0;
      rwBit  <= 1'b0;
      mAck   <= 1'b0;
    end else begin
      st     <= stNx;
      bitCnt <= bitNx;
      rwBit  <= rwNx;
      mAck   <= mAckNx;
    end
  end

  assign sdaOe = (st == S_ACKDEV) || (st == S_ACKHI) || (st == S_ACKLO) ||
                 ((st == S_TX) && !txBit);

endmodule

// File: rtl/i2c_mem_reader.sv
module i2c_mem_reader
  import i2crd_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        devSel,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memData
);

  dpCtl_t     dpCtl;
  logic       sclSync, sdaSync, sclRise, sclFall, startEv, stopEv, txBit;
  logic [7:0] rxByte;

  i2crd_datapath #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(dpCtl),
    .memData(memData), .sclSync(sclSync), .sdaSync(sdaSync),
    .sclRise(sclRise), .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv),
    .rxByte(rxByte), .txBit(txBit), .memAddr(memAddr)
  );

  i2crd_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sdaSync(sdaSync), .sclRise(sclRise),
    .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv), .rxByte(rxByte),
    .txBit(txBit), .devSel(devSel), .ctl(dpCtl), .sdaOe(sdaOe)
  );

endmodule

// File: rtl/i2crd_checker.sv
module i2crd_checker #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdaOe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              sclSync,
  input logic              startEv,
  input logic              stopEv,
  input logic              incStb,
  input logic              loadStb
);

  // R10: SDA moves only with SCL low, except as a result of START/STOP
  p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaOe) && !$past(startEv) && !$past(stopEv)) |-> !sclSync);

  // R9: a START always leaves SDA released
  p_start_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(startEv) |-> !sdaOe);

  // R11: a STOP always leaves SDA released
  p_stop_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopEv) |-> !sdaOe);

  // R5 / R6: a step adds exactly one, modulo the array size
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(incStb) |-> (memAddr == ADDR_W'($past(memAddr) + 1'b1)));

  // R8: without load or step the counter keeps its value
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(incStb) && !$past(loadStb)) |-> $stable(memAddr));

endmodule

bind i2c_mem_reader i2crd_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .memAddr(memAddr),
  .sclSync(sclSync), .startEv(startEv), .stopEv(stopEv),
  .incStb(dpCtl.incAddr), .loadStb(dpCtl.loadCnt)
);

// File: tb/tb_i2c_mem_reader.sv
`timescale 1ns/1ps
module tb_i2c_mem_reader;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        scl = 1'b1;
  logic        sdaM = 1'b1;
  logic        sdaOe;
  logic [13:0] memAddr;
  logic [7:0]  memData;
  logic        sdaBus;
  int          vecs = 0;
  int          errs = 0;
  int          refCnt = 0;

  always #4 clk = ~clk;

  // Memory model: content is a function of the address
  function automatic logic [7:0] memFn(input int a);
    return 8'((a * 29) ^ (a >> 6) ^ 8'h5A);
  endfunction

  assign memData = memFn(int'(memAddr));
  assign sdaBus  = sdaM & ~sdaOe;

  i2c_mem_reader dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus), .devSel(3'b101),
    .sdaOe(sdaOe), .memAddr(memAddr), .memData(memData)
  );

  task automatic cmp(input int got, input int exp, input string tag);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // One SCL period; SDA from the target is compared on every clock of the high phase
  task automatic bitOut(input logic b, input logic expOe, input string tag,
                        output logic busVal);
    repeat (5) @(negedge clk);
    sdaM = b;
    repeat (15) @(negedge clk);
    scl = 1'b1;
    busVal = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i >= 5 && i < 18) cmp(int'(sdaOe), int'(expOe), tag);
      if (i == 10) busVal = sdaBus;
    end
    scl = 1'b0;
  endtask

  task automatic startC();
    repeat (5) @(negedge clk); sdaM = 1'b1;
    repeat (10) @(negedge clk); scl = 1'b1;
    repeat (10) @(negedge clk); sdaM = 1'b0;
    repeat (10) @(negedge clk); scl = 1'b0;
  endtask

  task automatic stopC();
    repeat (5) @(negedge clk); sdaM = 1'b0;
    repeat (10) @(negedge clk); scl = 1'b1;
    repeat (10) @(negedge clk); sdaM = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] v, input logic expAck, input string tag);
    logic bv;
    for (int i = 7; i >= 0; i--) bitOut(v[i], 1'b0, tag, bv);
    bitOut(1'b1, expAck, tag, bv);
  endtask

  // R10: target's drive is held stable across each high phase (checked per clock)
  task automatic readByte(input logic [7:0] expB, input logic mack, input string tag);
    logic [7:0] got;
    logic bv;
    for (int i = 7; i >= 0; i--) begin
      bitOut(1'b1, ~expB[i], tag, bv);
      got[i] = bv;
    end
    cmp(int'(got), int'(expB), tag);
    bitOut(~mack, 1'b0, tag, bv);
    refCnt = (refCnt + 1) % 16384;
  endtask

  task automatic setAddr(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    startC();
    sendByte(8'hAA, 1'b1, tag);
    sendByte(hi, 1'b1, tag);
    sendByte(lo, 1'b1, tag);
    refCnt = (int'(hi & 8'h3F) << 8) | int'(lo);
    cmp(int'(memAddr), refCnt, tag);
    startC();
    sendByte(8'hAB, 1'b1, tag);
  endtask

  initial begin
    logic bv;
    repeat (10) @(negedge clk);
    cmp(int'(sdaOe), 0, "R12");
    cmp(int'(memAddr), 0, "R12");
    rstN = 1'b1;
    repeat (10) @(negedge clk);

    // Current-address read from reset state: R8, R4, R7
    startC();
    sendByte(8'hAB, 1'b1, "R1");
    readByte(memFn(refCnt), 1'b0, "R4");
    stopC();
    cmp(int'(memAddr), refCnt, "R7");
    cmp(int'(sdaOe), 0, "R7");

    // Wrong device address: no ack, bus ignored: R1
    startC();
    sendByte(8'hA1, 1'b0, "R1");
    for (int i = 0; i < 9; i++) bitOut(1'b1, 1'b0, "R1", bv);
    stopC();
    cmp(int'(memAddr), refCnt, "R1");

    // Random read with upper address bits set, sequential: R2, R3, R5
    setAddr(8'hC1, 8'h23, "R3");
    readByte(memFn(refCnt), 1'b1, "R5");
    readByte(memFn(refCnt), 1'b1, "R5");
    readByte(memFn(refCnt), 1'b0, "R5");
    stopC();
    cmp(int'(memAddr), refCnt, "R2");

    // Current-address read continues from previous transfer: R8
    startC();
    sendByte(8'hAB, 1'b1, "R8");
    readByte(memFn(refCnt), 1'b0, "R8");
    stopC();

    // Rollover at end of array: R6
    setAddr(8'h3F, 8'hFE, "R6");
    for (int i = 0; i < 4; i++) readByte(memFn(refCnt), (i != 3), "R6");
    stopC();
    cmp(int'(memAddr), 2, "R6");

    // START in the middle of the high address byte: R9
    startC();
    sendByte(8'hAA, 1'b1, "R9");
    for (int i = 0; i < 4; i++) bitOut(1'b0, 1'b0, "R9", bv);
    startC();
    cmp(int'(memAddr), refCnt, "R9");
    sendByte(8'hAB, 1'b1, "R9");
    readByte(memFn(refCnt), 1'b0, "R9");
    stopC();

    // STOP right after the address ack: R11
    startC();
    sendByte(8'hAA, 1'b1, "R11");
    stopC();
    cmp(int'(sdaOe), 0, "R11");
    cmp(int'(memAddr), refCnt, "R11");
    startC();
    sendByte(8'hAB, 1'b1, "R11");
    readByte(memFn(refCnt), 1'b0, "R11");
    stopC();

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule